// File: doc/BRIEF.md
# Processor Interrupt and Reset Controller

This block decides, at each instruction boundary of a 16-bit processor core, whether the core must enter an interrupt response and which vector type it must service. It takes three kinds of request: a level-sensitive maskable request that is gated by the interrupt enable flag, an edge-sensitive non-maskable request, and the single-step trap flag. The execution unit marks the last cycle of every instruction with a one-cycle strobe. On that strobe the block picks the winning request and raises a one-cycle service pulse with the vector type. For the maskable request it flags that the type must be fetched from the bus by an external acknowledge.

The block also qualifies the processor reset request. The request is synchronized and has to stay high for a minimum number of synchronized clocks before the core is held in reset, so a short glitch is ignored. While the core is held in reset, no service is started and any pending non-maskable event is dropped. When the request is released, a one-cycle restart pulse presents the fixed 20-bit restart fetch address.

All three asynchronous inputs (maskable, non-maskable and reset request) pass through a two-flop synchronizer before use. The acknowledge bus cycles, the vector table lookup and the storage of the flags belong to other blocks.

Top module: `irq_reset_ctrl`

## Requirements
- R1: When `instr_end` is high, `int_enable` is high and the synchronized maskable request is high, and no higher request is pending, `svc_start` is high for the one cycle after the strobe, with `svc_external` = 1 and `svc_type` = 0.
- R2: When `int_enable` is low, the maskable request never causes `svc_start`.
- R3: Requests are acted on only at an instruction boundary. `svc_start` is high only in the cycle after a cycle with `instr_end` high.
- R4: A low-to-high transition of `nmi_req` is latched and stays pending after the input returns low. At the next instruction boundary it is serviced with `svc_type` = 2 and `svc_external` = 0, whatever `int_enable` is.
- R5: One non-maskable edge causes exactly one service. The pending state clears when the event is serviced.
- R6: When `trap_flag` is high at an instruction boundary, a service with `svc_type` = 1 and `svc_external` = 0 starts.
- R7: When several requests compete, the non-maskable event wins over the trap, and the trap wins over the maskable request. The losers are not consumed.
- R8: `core_reset` rises only after the synchronized `reset_req` has been high for 4 consecutive clocks. A request that is high for fewer synchronized clocks has no effect.
- R9: While `core_reset` is high, no service starts, and a non-maskable event that was pending when reset took hold is discarded.
- R10: When a qualified reset is released, `restart_go` is high for exactly one cycle, in the same cycle that `core_reset` falls, and `restart_addr` = 20'hFFFF0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| intr_req | input | 1 | Maskable request, level-sensitive, active high |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| reset_req | input | 1 | Processor reset request, active high |
| trap_flag | input | 1 | Single-step flag from the flag storage |
| int_enable | input | 1 | Interrupt enable flag from the flag storage |
| instr_end | input | 1 | Last-cycle-of-instruction strobe from the execution unit |
| svc_start | output | 1 | One-cycle pulse: begin an interrupt response |
| svc_type | output | 8 | Vector type to service; 0 when `svc_external` is set |
| svc_external | output | 1 | Type must be read from the bus by an acknowledge cycle |
| core_reset | output | 1 | Holds the core in reset |
| restart_go | output | 1 | One-cycle pulse when a qualified reset is released |
| restart_addr | output | 20 | Restart fetch address; 20'hFFFF0 while `restart_go` is high, 0 otherwise |

## Verification
A corrupted pending bit for the non-maskable request shows up at the next instruction strobe. It either starts a type 2 service that nobody requested or drops one that was owed, and a second strobe shows whether the bit cleared. A wrong priority choice or a wrong masking decision appears as a wrong `svc_type` or `svc_external` in the cycle after the strobe. A miscounted reset qualifier shows as `core_reset` rising after a short glitch, or failing to rise within a few cycles of a long request. A bad release path shows as a missing or mis-addressed `restart_go` in the cycle that `core_reset` falls.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int TYPE_W = 8;
  localparam int ADDR_W = 20;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_TRAP = 2'd2,
    SRC_MASK = 2'd3
  } src_e;

  localparam logic [TYPE_W-1:0] VEC_TRAP = 8'd1;
  localparam logic [TYPE_W-1:0] VEC_NMI  = 8'd2;
  localparam logic [ADDR_W-1:0] RESTART  = 20'hFFFF0;
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = d_async;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irc_nmi_latch.sv
module irc_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_s,
  input  logic take,
  input  logic flush,
  output logic pending
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = nmi_s && !prev_q;
    prev_d = nmi_s;
    if (flush)      pend_d = 1'b0;
    else if (rise)  pend_d = 1'b1;
    else if (take)  pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irc_rst_filter.sv
module irc_rst_filter #(
  parameter int MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic hold,
  output logic release_pulse
);
  localparam int CNT_W = (MIN_CYCLES > 1) ? $clog2(MIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             rel_q, rel_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == CNT_TOP);
    if (!req_s)      cnt_d = '0;
    else if (at_top) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
    hold_d = req_s && (at_top || hold_q);
    rel_d  = hold_q && !req_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      rel_q  <= rel_d;
    end
  end

  assign hold          = hold_q;
  assign release_pulse = rel_q;
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter
  import irc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              nmi_pend,
  input  logic              trap_on,
  input  logic              mask_req,
  input  logic              mask_en,
  input  logic              blocked,
  output logic              nmi_take,
  output logic              svc_q_o,
  output logic [TYPE_W-1:0] type_q_o,
  output logic              ext_q_o
);
  src_e              pick;
  logic              fire;
  logic              svc_q, svc_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic              ext_q, ext_d;
  logic              load_en;

  always_comb begin
    if (nmi_pend)                 pick = SRC_NMI;
    else if (trap_on)             pick = SRC_TRAP;
    else if (mask_req && mask_en) pick = SRC_MASK;
    else                          pick = SRC_NONE;
    fire     = boundary && !blocked && (pick != SRC_NONE);
    nmi_take = fire && (pick == SRC_NMI);
    svc_d    = fire;
    load_en  = fire;
    unique case (pick)
      SRC_NMI:  begin type_d = VEC_NMI;  ext_d = 1'b0; end
      SRC_TRAP: begin type_d = VEC_TRAP; ext_d = 1'b0; end
      SRC_MASK: begin type_d = '0;       ext_d = 1'b1; end
      default:  begin type_d = type_q;   ext_d = ext_q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 1'b0;
    else        svc_q <= svc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      ext_q  <= 1'b0;
    end else if (load_en) begin
      type_q <= type_d;
      ext_q  <= ext_d;
    end
  end

  assign svc_q_o  = svc_q;
  assign type_q_o = type_q;
  assign ext_q_o  = ext_q;
endmodule

// File: rtl/irq_reset_ctrl.sv
module irq_reset_ctrl
  import irc_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int RST_MIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intr_req,
  input  logic              nmi_req,
  input  logic              reset_req,
  input  logic              trap_flag,
  input  logic              int_enable,
  input  logic              instr_end,
  output logic              svc_start,
  output logic [TYPE_W-1:0] svc_type,
  output logic              svc_external,
  output logic              core_reset,
  output logic              restart_go,
  output logic [ADDR_W-1:0] restart_addr
);
  localparam int N_ASYNC = 3;
  localparam int IDX_INTR = 0;
  localparam int IDX_NMI  = 1;
  localparam int IDX_RST  = 2;

  logic [N_ASYNC-1:0] raw_in, synced;
  logic nmi_pend, nmi_take, hold, rel;
  logic svc_q;
  logic [TYPE_W-1:0] type_q;
  logic ext_q;

  assign raw_in = {reset_req, nmi_req, intr_req};

  irc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(synced)
  );

  irc_rst_filter #(.MIN_CYCLES(RST_MIN_CYCLES)) u_rstf (
    .clk(clk), .rst_n(rst_n), .req_s(synced[IDX_RST]),
    .hold(hold), .release_pulse(rel)
  );

  irc_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_s(synced[IDX_NMI]),
    .take(nmi_take), .flush(hold), .pending(nmi_pend)
  );

  irc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .boundary(instr_end),
    .nmi_pend(nmi_pend), .trap_on(trap_flag),
    .mask_req(synced[IDX_INTR]), .mask_en(int_enable),
    .blocked(hold), .nmi_take(nmi_take),
    .svc_q_o(svc_q), .type_q_o(type_q), .ext_q_o(ext_q)
  );

  assign svc_start    = svc_q && !hold;
  assign svc_type     = type_q;
  assign svc_external = ext_q;
  assign core_reset   = hold;
  assign restart_go   = rel;
  assign restart_addr = rel ? RESTART : '0;
endmodule

// File: rtl/irq_reset_ctrl_checker.sv
module irq_reset_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_end,
  input logic       svc_start,
  input logic [7:0] svc_type,
  input logic       svc_external,
  input logic       core_reset,
  input logic       restart_go,
  input logic [19:0] restart_addr
);
  assert_start_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_start |-> $past(instr_end));

  assert_ext_means_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    svc_start |-> (svc_external == (svc_type == 8'd0)));

  assert_type_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_start |-> (svc_type == 8'd0 || svc_type == 8'd1 || svc_type == 8'd2));

  assert_no_svc_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> !svc_start);

  assert_release_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_reset) |-> (restart_go && restart_addr == 20'hFFFF0));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_go |=> !restart_go);
endmodule

bind irq_reset_ctrl irq_reset_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .svc_start(svc_start),
  .svc_type(svc_type), .svc_external(svc_external), .core_reset(core_reset),
  .restart_go(restart_go), .restart_addr(restart_addr)
);

// File: tb/irq_reset_ctrl_bench.sv
module irq_reset_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic intr_req, nmi_req, reset_req, trap_flag, int_enable, instr_end;
  logic svc_start, svc_external, core_reset, restart_go;
  logic [7:0] svc_type;
  logic [19:0] restart_addr;

  int checks = 0;
  int failures = 0;
  int restarts = 0;
  bit rst_seen = 0;
  bit done = 0;
  logic [8:0] expq [$];   // {external, type}
  string      tagq [$];

  always #5 clk = ~clk;

  irq_reset_ctrl u_irq_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .nmi_req(nmi_req),
    .reset_req(reset_req), .trap_flag(trap_flag), .int_enable(int_enable),
    .instr_end(instr_end), .svc_start(svc_start), .svc_type(svc_type),
    .svc_external(svc_external), .core_reset(core_reset),
    .restart_go(restart_go), .restart_addr(restart_addr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each service pulse and restart pulse against expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (core_reset) rst_seen = 1;
      if (svc_start) begin
        if (expq.size() == 0) check(0, "R2/R3/R5/R9 unexpected service", {svc_external, svc_type}, 0);
        else begin
          logic [8:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check({svc_external, svc_type} == e, t, {svc_external, svc_type}, e);
        end
      end
      if (restart_go) begin
        restarts++;
        check(restart_addr == 20'hFFFF0, "R10 restart address", restart_addr, 20'hFFFF0);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one instruction boundary; pushes the expected service (if any)
  task automatic boundary(input bit expect_svc, input bit ext, input logic [7:0] ty, input string tag);
    if (expect_svc) begin
      expq.push_back({ext, ty});
      tagq.push_back(tag);
    end
    instr_end = 1'b1;
    @(negedge clk);
    instr_end = 1'b0;
    wait_cyc(2);
  endtask

  task automatic drain(input string tag);
    check(expq.size() == 0, tag, expq.size(), 0);
    expq.delete();
    tagq.delete();
  endtask

  task automatic nmi_edge();
    nmi_req = 1'b1; wait_cyc(2); nmi_req = 1'b0; wait_cyc(4);
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {intr_req, nmi_req, reset_req, trap_flag, int_enable, instr_end} = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check(!svc_start && !core_reset && !restart_go && restart_addr == 0,
          "reset state", {svc_start, core_reset, restart_go}, 0);

    // R1: maskable request with enable
    int_enable = 1; intr_req = 1; wait_cyc(4);
    boundary(1, 1, 8'd0, "R1 maskable service");
    // R3: request held but no boundary -> nothing
    wait_cyc(10);
    drain("R3 no service without boundary");
    // R2: masked
    int_enable = 0;
    boundary(0, 0, 0, "R2"); boundary(0, 0, 0, "R2");
    drain("R2 masked request ignored");
    intr_req = 0; wait_cyc(4);

    // R4: edge latched, input already low, enable clear
    nmi_edge();
    boundary(1, 0, 8'd2, "R4 nmi serviced after input low");
    // R5: single service per edge
    boundary(0, 0, 0, "R5");
    drain("R5 one edge one service");

    // R6: trap
    trap_flag = 1;
    boundary(1, 0, 8'd1, "R6 trap type");
    // R7: nmi beats trap; trap remains
    nmi_edge();
    boundary(1, 0, 8'd2, "R7 nmi over trap");
    boundary(1, 0, 8'd1, "R7 trap after nmi");
    // R7: trap beats maskable; maskable next once trap clears
    int_enable = 1; intr_req = 1; wait_cyc(4);
    boundary(1, 0, 8'd1, "R7 trap over maskable");
    trap_flag = 0;
    boundary(1, 1, 8'd0, "R7 maskable after trap");
    // R7: nmi beats maskable
    nmi_edge();
    boundary(1, 0, 8'd2, "R7 nmi over maskable");
    intr_req = 0; int_enable = 0; wait_cyc(4);
    drain("R7 queue empty");

    // R8: short request ignored
    rst_seen = 0;
    reset_req = 1; wait_cyc(3); reset_req = 0; wait_cyc(10);
    check(!rst_seen, "R8 short reset ignored", rst_seen, 0);
    check(restarts == 0, "R8 no restart after short pulse", restarts, 0);

    // R8/R9: long request with pending nmi
    nmi_edge();
    reset_req = 1; wait_cyc(9);
    check(core_reset, "R8 long reset qualified", core_reset, 1);
    boundary(0, 0, 0, "R9");
    reset_req = 0; wait_cyc(6);
    check(!core_reset, "R10 reset released", core_reset, 0);
    check(restarts == 1, "R10 one restart pulse", restarts, 1);
    boundary(0, 0, 0, "R9");
    drain("R9 pending nmi discarded by reset");

    // R4 again after reset: fresh edge still works
    nmi_edge();
    boundary(1, 0, 8'd2, "R4 nmi after reset");
    drain("R4 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule